// File: doc/BRIEF.md
# Dual-Clock FIFO with Per-Domain Status

This block carries data words from a producer running on one clock to a consumer running on an unrelated clock. The producer pushes a word by raising its write enable for one write-clock cycle. The consumer pops a word by raising its read enable for one read-clock cycle, and the word appears on the output one read-clock edge later. A single active-low clear, applied without regard to either clock, returns the whole block to the empty state.

Each side has its own full flag, empty flag and fill level, all registered in that side's clock. Each side tracks its own position as a Gray-coded counter one bit wider than the address. That counter crosses to the other side through a two-stage synchronizer. On each side, the local position and the synchronized remote position are turned back into binary and subtracted to form the fill level. Because the remote view always lags, the write side reports a fill that is at or above the real fill, and the read side reports a fill that is at or below it. Neither side can therefore overrun or underrun the storage.

Writes into the storage array pass through a register stage before they land. The write position that is published to the read side only advances once the word is in the array. This means the read side can never see a slot as filled before its data is there.

Top module: `xclk_fifo`

## Requirements
- R1: While arst_n is low, and right after it is asserted, wr_full and rd_full are 0, wr_empty and rd_empty are 1, wr_level and rd_level are 0, and rd_data is 0.
- R2: Words leave through rd_data in the order they were accepted, with none lost or duplicated, including after a clear.
- R3: wr_level is never below the true number of stored words. An accepted write raises wr_level at the write-clock edge that takes it in.
- R4: rd_level is never above the true number of stored words.
- R5: A write request while wr_full is 1 is ignored: wr_level does not change and no stored word is overwritten.
- R6: A read request while rd_empty is 1 is ignored: rd_level stays 0 and rd_data holds its value.
- R7: An accepted read presents its word on rd_data at the next read-clock edge.
- R8: A word written into an empty FIFO clears rd_empty within two write-clock edges plus four read-clock edges of the write being accepted.
- R9: On each side, full is 1 exactly when that side's level equals the depth, and empty is 1 exactly when that side's level is 0.
- R10: Once traffic stops, both levels settle to the true count within a few cycles of each clock. With 16 stored words both full flags go to 1; with none stored both empty flags go to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| arst_n | input | 1 | Asynchronous active-low clear of the whole block |
| wr_en | input | 1 | Write request, one word per write-clock cycle |
| wr_data | input | DATA_W | Word to write |
| rd_en | input | 1 | Read request, one word per read-clock cycle |
| rd_data | output | DATA_W | Word read, valid one read-clock edge after an accepted read |
| wr_full | output | 1 | Full, write-clock domain |
| wr_empty | output | 1 | Empty, write-clock domain |
| wr_level | output | ADDR_W+1 | Stored-word count, write-clock domain |
| rd_full | output | 1 | Full, read-clock domain |
| rd_empty | output | 1 | Empty, read-clock domain |
| rd_level | output | ADDR_W+1 | Stored-word count, read-clock domain |

## Verification
Timing on the write side is fixed. An accepted write moves wr_level one write edge later. The word lands in the array and the published position moves at the second write edge. The read side then needs two synchronizer edges plus one flag register edge, so the bench waits two write edges and four read edges before it expects rd_empty to drop. On the read side, rd_data is compared at the read-clock falling edge that follows the accepting rising edge.

Between these fixed points, the two levels may legitimately lag. The bench therefore checks each level only against the bound it must keep, using accept counts taken when each request is driven. It demands exact values only after enough idle cycles on both clocks for the counts to settle.

// File: rtl/afifo_pkg.sv
`timescale 1ns/1ps
// afifo_pkg: shared Gray/binary conversion helpers for the dual-clock FIFO.
// Assumes pointer widths of at most 32 bits; callers cast to their width.
package afifo_pkg;

    // Binary to reflected Gray code.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary (prefix XOR from the top bit down).
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b = g;
        for (int i = 1; i < 32; i++) begin
            b = b ^ (g >> i);
        end
        return b;
    endfunction

endpackage

// File: rtl/afifo_sync.sv
`timescale 1ns/1ps
// afifo_sync: multi-stage flop chain that brings a Gray-coded pointer into
// the destination clock domain. Assumes the source changes at most one bit
// per source cycle and is driven straight from a register.
module afifo_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the incoming value through the chain; clear on reset.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stg <= '0;
        else         stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/afifo_wr_ctl.sv
`timescale 1ns/1ps
// afifo_wr_ctl: write-domain pointer, flags and level.
// Keeps a local write pointer for full/level decisions and a separate
// published pointer that only advances once the storage write has landed.
// Assumes rgray_sync is the read pointer already synchronized to wr_clk.
module afifo_wr_ctl #(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        arst_n,
    input  logic        wr_en,
    input  logic        commit,
    input  logic [AW:0] rgray_sync,
    output logic        push,
    output logic [AW-1:0] waddr,
    output logic [AW:0] wgray_pub,
    output logic        wr_full,
    output logic        wr_empty,
    output logic [AW:0] wr_level
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH = PW'(1 << AW);

    logic [PW-1:0] wbin, wbin_n, pub_bin, pub_n, rbin_s, lvl_n;

    // Accept a write only when not full; compute next pointer and level.
    always_comb begin
        push   = wr_en & ~wr_full;
        wbin_n = wbin + PW'(push);
        rbin_s = PW'(afifo_pkg::from_gray(32'(rgray_sync)));
        lvl_n  = wbin_n - rbin_s;
        pub_n  = pub_bin + PW'(commit);
    end

    // Register the local pointer and the pessimistic write-side status.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            wbin     <= '0;
            wr_level <= '0;
            wr_full  <= 1'b0;
            wr_empty <= 1'b1;
        end else begin
            wbin     <= wbin_n;
            wr_level <= lvl_n;
            wr_full  <= (lvl_n == DEPTH);
            wr_empty <= (lvl_n == '0);
        end
    end

    // Advance the published pointer as stored words land; Gray leaves from a flop.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            pub_bin   <= '0;
            wgray_pub <= '0;
        end else begin
            pub_bin   <= pub_n;
            wgray_pub <= PW'(afifo_pkg::to_gray(32'(pub_n)));
        end
    end

    assign waddr = wbin[AW-1:0];

    // R5
    no_wr_when_full_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (wr_full && wr_en) |=> $stable(wbin));
    // R3
    wr_level_bound_chk: assert property (@(posedge clk) disable iff (!arst_n)
        wr_level <= DEPTH);
    // R8
    pub_lag_chk: assert property (@(posedge clk) disable iff (!arst_n)
        PW'(wbin - pub_bin) <= PW'(1));
    // R2
    wgray_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $countones(wgray_pub ^ $past(wgray_pub)) <= 1);
endmodule

// File: rtl/afifo_rd_ctl.sv
`timescale 1ns/1ps
// afifo_rd_ctl: read-domain pointer, flags and level.
// Assumes wgray_sync is the published write pointer synchronized to rd_clk,
// so any lag only makes the reported level smaller than the truth.
module afifo_rd_ctl #(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        arst_n,
    input  logic        rd_en,
    input  logic [AW:0] wgray_sync,
    output logic        pop,
    output logic [AW-1:0] raddr,
    output logic [AW:0] rgray,
    output logic        rd_full,
    output logic        rd_empty,
    output logic [AW:0] rd_level
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH = PW'(1 << AW);

    logic [PW-1:0] rbin, rbin_n, wbin_s, lvl_n;

    // Accept a read only when not empty; compute next pointer and level.
    always_comb begin
        pop    = rd_en & ~rd_empty;
        rbin_n = rbin + PW'(pop);
        wbin_s = PW'(afifo_pkg::from_gray(32'(wgray_sync)));
        lvl_n  = wbin_s - rbin_n;
    end

    // Register pointer, outgoing Gray value and read-side status.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            rbin     <= '0;
            rgray    <= '0;
            rd_level <= '0;
            rd_full  <= 1'b0;
            rd_empty <= 1'b1;
        end else begin
            rbin     <= rbin_n;
            rgray    <= PW'(afifo_pkg::to_gray(32'(rbin_n)));
            rd_level <= lvl_n;
            rd_full  <= (lvl_n == DEPTH);
            rd_empty <= (lvl_n == '0);
        end
    end

    assign raddr = rbin[AW-1:0];

    // R6
    no_rd_when_empty_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (rd_empty && rd_en) |=> $stable(rbin));
    // R4
    rd_level_bound_chk: assert property (@(posedge clk) disable iff (!arst_n)
        rd_level <= DEPTH);
    // R2
    rgray_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/afifo_store.sv
`timescale 1ns/1ps
// afifo_store: two-port register array. The write port registers address,
// data and enable before the array write, and reports the landing as commit.
// The read port registers the selected word into rd_data on an accepted pop.
module afifo_store #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          arst_n,
    input  logic          push,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    output logic          commit,
    input  logic          pop,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] st_addr;
    logic [DW-1:0] st_data;

    // Input register stage of the write port.
    always_ff @(posedge wr_clk or negedge arst_n) begin
        if (!arst_n) begin
            commit  <= 1'b0;
            st_addr <= '0;
            st_data <= '0;
        end else begin
            commit  <= push;
            st_addr <= waddr;
            st_data <= wdata;
        end
    end

    // Array write from the registered inputs.
    always_ff @(posedge wr_clk) begin
        if (commit) mem[st_addr] <= st_data;
    end

    // Registered read of the head word.
    always_ff @(posedge rd_clk or negedge arst_n) begin
        if (!arst_n)  rd_data <= '0;
        else if (pop) rd_data <= mem[raddr];
    end

    // R6
    rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!arst_n)
        !pop |=> $stable(rd_data));
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
// xclk_fifo: dual-clock FIFO with full, empty and level in each domain.
// Depth is 2**ADDR_W. Assumes wr_clk and rd_clk are free-running and that
// arst_n may change at any time; both domains clear together.
module xclk_fifo #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              arst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_full,
    output logic              wr_empty,
    output logic [ADDR_W:0]   wr_level,
    output logic              rd_full,
    output logic              rd_empty,
    output logic [ADDR_W:0]   rd_level
);
    localparam int PW = ADDR_W + 1;

    logic              push, pop, commit;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PW-1:0]     wgray_pub, wgray_sync, rgray, rgray_sync;

    afifo_wr_ctl #(.AW(ADDR_W)) u_wr (
        .clk(wr_clk), .arst_n(arst_n), .wr_en(wr_en), .commit(commit),
        .rgray_sync(rgray_sync), .push(push), .waddr(waddr),
        .wgray_pub(wgray_pub), .wr_full(wr_full), .wr_empty(wr_empty),
        .wr_level(wr_level)
    );

    afifo_rd_ctl #(.AW(ADDR_W)) u_rd (
        .clk(rd_clk), .arst_n(arst_n), .rd_en(rd_en),
        .wgray_sync(wgray_sync), .pop(pop), .raddr(raddr), .rgray(rgray),
        .rd_full(rd_full), .rd_empty(rd_empty), .rd_level(rd_level)
    );

    afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rd_clk), .arst_n(arst_n), .d(wgray_pub), .q(wgray_sync)
    );

    afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wr_clk), .arst_n(arst_n), .d(rgray), .q(rgray_sync)
    );

    afifo_store #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .arst_n(arst_n), .push(push),
        .waddr(waddr), .wdata(wr_data), .commit(commit), .pop(pop),
        .raddr(raddr), .rd_data(rd_data)
    );

    // R9
    wr_flag_chk: assert property (@(posedge wr_clk) disable iff (!arst_n)
        !(wr_full && wr_empty));
    // R9
    rd_flag_chk: assert property (@(posedge rd_clk) disable iff (!arst_n)
        !(rd_full && rd_empty));
endmodule

// File: tb/sim_xclk_fifo.sv
`timescale 1ns/1ps
module sim_xclk_fifo;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic          wr_clk = 1'b0, rd_clk = 1'b0, arst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          wr_full, wr_empty, rd_full, rd_empty;
    logic [AW:0]   wr_level, rd_level;

    int tests = 0, fails = 0;
    int nwr = 0, nrd = 0;
    logic [DW-1:0] mdl [$];
    bit            pend = 0;
    logic [DW-1:0] pend_exp = '0;
    logic [DW-1:0] last_q = '0;

    always #4   wr_clk = ~wr_clk;
    always #6.5 rd_clk = ~rd_clk;

    xclk_fifo #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .arst_n(arst_n), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .wr_full(wr_full), .wr_empty(wr_empty), .wr_level(wr_level),
        .rd_full(rd_full), .rd_empty(rd_empty), .rd_level(rd_level)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One write-clock cycle: bound checks, then drive a request.
    task automatic wr_cycle(input bit en, input logic [DW-1:0] d);
        @(negedge wr_clk);
        chk(int'(wr_level) >= nwr - nrd, "R3", int'(wr_level), nwr - nrd);
        chk(wr_full == (wr_level == DEPTH) && wr_empty == (wr_level == 0),
            "R9", int'(wr_level), int'(wr_level));
        wr_en = en;
        wr_data = d;
        if (en && !wr_full) begin
            mdl.push_back(d);
            nwr++;
        end
    endtask

    // One read-clock cycle: check last result and bounds, then drive a request.
    task automatic rd_cycle(input bit en);
        @(negedge rd_clk);
        if (pend) chk(rd_data == pend_exp, "R2/R7", int'(rd_data), int'(pend_exp));
        else      chk(rd_data == last_q, "R6", int'(rd_data), int'(last_q));
        chk(int'(rd_level) <= nwr - nrd, "R4", int'(rd_level), nwr - nrd);
        chk(rd_full == (rd_level == DEPTH) && rd_empty == (rd_level == 0),
            "R9", int'(rd_level), int'(rd_level));
        last_q = rd_data;
        rd_en = en;
        pend = 0;
        if (en && !rd_empty) begin
            if (mdl.size() == 0) chk(0, "R2", 0, 1);
            else begin
                pend = 1;
                pend_exp = mdl.pop_front();
                nrd++;
            end
        end
    endtask

    task automatic chk_cleared(input string tag);
        chk(wr_full == 0 && rd_full == 0, tag, int'({wr_full, rd_full}), 0);
        chk(wr_empty == 1 && rd_empty == 1, tag, int'({wr_empty, rd_empty}), 3);
        chk(wr_level == 0 && rd_level == 0, tag, int'(wr_level) + int'(rd_level), 0);
        chk(rd_data == 0, tag, int'(rd_data), 0);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: state during and after the initial clear
        #20 chk_cleared("R1");
        #76 arst_n = 1'b1;
        @(negedge wr_clk);
        chk_cleared("R1");

        // Fill to full, then attempt writes while full (R5)
        for (int i = 0; i < DEPTH; i++) wr_cycle(1'b1, DW'(i + 1));
        wr_cycle(1'b0, '0);
        chk(wr_level == DEPTH, "R3", int'(wr_level), DEPTH);
        chk(wr_full == 1, "R10", int'(wr_full), 1);
        for (int i = 0; i < 3; i++) wr_cycle(1'b1, DW'(8'hA0 + i));
        wr_cycle(1'b0, '0);
        chk(wr_level == DEPTH, "R5", int'(wr_level), DEPTH);
        repeat (6) @(negedge rd_clk);
        chk(rd_full == 1 && rd_level == DEPTH, "R10", int'(rd_level), DEPTH);

        // Drain everything, then read while empty (R6)
        for (int i = 0; i < DEPTH; i++) rd_cycle(1'b1);
        rd_cycle(1'b0);
        chk(rd_empty == 1 && rd_level == 0, "R10", int'(rd_level), 0);
        for (int i = 0; i < 3; i++) rd_cycle(1'b1);
        rd_cycle(1'b0);
        chk(rd_level == 0, "R6", int'(rd_level), 0);
        repeat (6) @(negedge wr_clk);
        chk(wr_empty == 1 && wr_level == 0, "R10", int'(wr_level), 0);

        // Single-word latency into an empty FIFO (R3, R8)
        wr_cycle(1'b1, 8'h5A);
        wr_cycle(1'b0, '0);
        chk(wr_level == 1, "R3", int'(wr_level), 1);
        @(posedge wr_clk);
        repeat (4) @(posedge rd_clk);
        @(negedge rd_clk);
        chk(rd_empty == 0, "R8", int'(rd_empty), 0);
        rd_cycle(1'b1);
        rd_cycle(1'b0);

        // Random concurrent traffic on unrelated clocks (R2, R3, R4)
        fork
            begin
                for (int i = 0; i < 3000; i++)
                    wr_cycle(1'($urandom_range(1, 0)), DW'($urandom));
                wr_cycle(1'b0, '0);
            end
            begin
                for (int i = 0; i < 2000; i++)
                    rd_cycle($urandom_range(2, 0) != 0);
                rd_cycle(1'b0);
            end
        join
        repeat (8) @(negedge rd_clk);
        while (!rd_empty) rd_cycle(1'b1);
        rd_cycle(1'b0);
        chk(mdl.size() == 0, "R2", mdl.size(), 0);

        // Asynchronous clear with words stored (R1), then traffic after it (R2)
        for (int i = 0; i < 5; i++) wr_cycle(1'b1, DW'(8'h30 + i));
        wr_cycle(1'b0, '0);
        repeat (8) @(negedge rd_clk);
        rd_cycle(1'b1);
        rd_cycle(1'b0);
        #2 arst_n = 1'b0;
        #1 chk_cleared("R1");
        mdl.delete();
        nwr = 0;
        nrd = 0;
        pend = 0;
        last_q = '0;
        @(negedge wr_clk);
        arst_n = 1'b1;
        wr_cycle(1'b1, 8'hC1);
        wr_cycle(1'b1, 8'hC2);
        wr_cycle(1'b0, '0);
        repeat (8) @(negedge rd_clk);
        rd_cycle(1'b1);
        rd_cycle(1'b1);
        rd_cycle(1'b0);
        chk(mdl.size() == 0 && rd_empty == 1, "R2", mdl.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule